// File: doc/BRIEF.md
# Buffered Torus Router Switch

This block is one switch of a unidirectional two-dimensional torus overlay network. Packets arrive from the west neighbour, the north neighbour and the local processing element (PE). They leave towards the east neighbour, the south neighbour or the local PE. Routing is dimension-ordered: a packet moves east along its row until its x coordinate matches the switch, then south along the column until its y coordinate matches, and then it exits locally. No packet is ever misrouted.

A west packet that has reached its column must leave the row. It goes into a turn queue instead of competing directly for an output. The queue depth is fixed at build time so that regulated traffic cannot fill it. No flow-control wire runs between neighbouring switches. North traffic always wins its output, and the queue head drains one entry per cycle when its output is free. The PE injects only when the switch raises the grant for the output the packet needs.

If a write ever arrives while the queue is full and nothing leaves in that cycle, the packet is discarded and a sticky overflow flag is raised. Every output is registered, so each hop costs one cycle.

Top module: `tor_switch`

## Requirements
- R1: A synchronous active-high reset clears all three output valids and the overflow flag and empties the turn queue. While no PE request is present, the grant stays low.
- R2: A valid west packet whose x coordinate differs from MY_X appears on the east output exactly one cycle later, with its coordinates and payload unchanged. It is never delayed.
- R3: A valid north packet appears exactly one cycle later, with its contents unchanged. It goes on the south output when its y coordinate differs from MY_Y and on the local output when it equals MY_Y.
- R4: A valid west packet whose x coordinate equals MY_X enters the turn queue. It leaves through south (y differs from MY_Y) or local (y equals MY_Y), at the earliest two cycles after it arrived.
- R5: The queue head is held while a north packet takes the output the head needs. At most one entry leaves the queue per cycle.
- R6: A granted PE packet appears one cycle later on east when its x differs from MY_X, otherwise on south when its y differs from MY_Y, otherwise on local.
- R7: The PE grant is low when the needed output is claimed in that cycle. East is claimed by a west pass-through packet. South or local is claimed by a north packet or by a queue head that wants it. Otherwise the grant follows the PE valid.
- R8: A queue write while the queue holds TURN_DEPTH entries and no entry leaves is dropped. It raises the overflow flag, and the flag stays set until reset.
- R9: Packets from the same input that leave through the same output keep their arrival order, including after the queue head has been blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| w_valid | input | 1 | West input packet valid |
| w_dx | input | XW | West packet destination x |
| w_dy | input | YW | West packet destination y |
| w_data | input | PW | West packet payload |
| n_valid | input | 1 | North input packet valid |
| n_dx | input | XW | North packet destination x |
| n_dy | input | YW | North packet destination y |
| n_data | input | PW | North packet payload |
| pe_valid | input | 1 | PE injection request |
| pe_dx | input | XW | PE packet destination x |
| pe_dy | input | YW | PE packet destination y |
| pe_data | input | PW | PE packet payload |
| pe_grant | output | 1 | PE packet is taken this cycle |
| e_valid | output | 1 | East output valid |
| e_dx | output | XW | East packet destination x |
| e_dy | output | YW | East packet destination y |
| e_data | output | PW | East packet payload |
| s_valid | output | 1 | South output valid |
| s_dx | output | XW | South packet destination x |
| s_dy | output | YW | South packet destination y |
| s_data | output | PW | South packet payload |
| l_valid | output | 1 | Local output valid |
| l_dx | output | XW | Local packet destination x |
| l_dy | output | YW | Local packet destination y |
| l_data | output | PW | Local packet payload |
| ovf | output | 1 | Sticky turn-queue overflow flag |

## Verification
The stimulus covers four groups of patterns:
- Lone west, north and PE packets aimed at each output establish the fixed routing and the exact one-cycle or two-cycle latency of each path.
- West pass-through and north traffic paired with a PE request for the same output separate the grant rules from plain routing.
- A turning west packet that meets continuous north traffic for the south output shows that the head waits rather than being deflected, and that the order is kept once it drains.
- A long collision that writes one packet more than the queue can hold shows that exactly that packet is lost, the flag is raised and stays set, and reset clears it.

// File: rtl/tor_pkg.sv
package tor_pkg;

  localparam int NUM_OUT = 3;

  typedef enum logic [1:0] {
    DIR_E = 2'd0,
    DIR_S = 2'd1,
    DIR_L = 2'd2
  } dir_e;

  typedef enum logic [2:0] {
    SRC_NONE = 3'd0,
    SRC_W    = 3'd1,
    SRC_N    = 3'd2,
    SRC_Q    = 3'd3,
    SRC_P    = 3'd4
  } src_e;

  // Dimension-ordered decision for a packet still inside its row.
  function automatic dir_e row_route(int dx, int dy, int mx, int my);
    if (dx != mx) return DIR_E;
    if (dy != my) return DIR_S;
    return DIR_L;
  endfunction

  // Decision for a packet already travelling down the column.
  function automatic dir_e col_route(int dy, int my);
    if (dy != my) return DIR_S;
    return DIR_L;
  endfunction

endpackage

// File: rtl/tor_fifo.sv
module tor_fifo #(
  parameter int W     = 36,
  parameter int DEPTH = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full,
  output logic         drop
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [CW-1:0] count;
  logic          do_wr, do_rd;

  assign empty = (count == '0);
  assign full  = (count == FULLC);
  assign do_rd = pop && !empty;
  assign do_wr = push && (!full || do_rd);
  assign drop  = push && full && !do_rd;
  assign dout  = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (do_wr) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_wr) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (do_rd) rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/tor_arb.sv
module tor_arb
  import tor_pkg::*;
(
  input  logic w_valid,
  input  dir_e w_dir,
  input  logic n_valid,
  input  dir_e n_dir,
  input  logic q_avail,
  input  dir_e q_dir,
  input  logic pe_valid,
  input  dir_e pe_dir,
  output logic w_turn,
  output logic q_pop,
  output logic pe_grant,
  output src_e sel_e,
  output src_e sel_s,
  output src_e sel_l
);
  logic w_east, n_s, n_l, q_s, q_l;
  logic busy_e, busy_s, busy_l;

  assign w_east = w_valid && (w_dir == DIR_E);
  assign w_turn = w_valid && (w_dir != DIR_E);
  assign n_s    = n_valid && (n_dir == DIR_S);
  assign n_l    = n_valid && (n_dir == DIR_L);
  assign q_s    = q_avail && (q_dir == DIR_S);
  assign q_l    = q_avail && (q_dir == DIR_L);

  assign q_pop  = (q_s && !n_s) || (q_l && !n_l);

  assign busy_e = w_east;
  assign busy_s = n_s || q_s;
  assign busy_l = n_l || q_l;

  always_comb begin
    case (pe_dir)
      DIR_E:   pe_grant = pe_valid && !busy_e;
      DIR_S:   pe_grant = pe_valid && !busy_s;
      default: pe_grant = pe_valid && !busy_l;
    endcase
  end

  always_comb begin
    sel_e = SRC_NONE;
    if (w_east)                              sel_e = SRC_W;
    else if (pe_grant && (pe_dir == DIR_E))  sel_e = SRC_P;

    sel_s = SRC_NONE;
    if (n_s)                                 sel_s = SRC_N;
    else if (q_s)                            sel_s = SRC_Q;
    else if (pe_grant && (pe_dir == DIR_S))  sel_s = SRC_P;

    sel_l = SRC_NONE;
    if (n_l)                                 sel_l = SRC_N;
    else if (q_l)                            sel_l = SRC_Q;
    else if (pe_grant && (pe_dir == DIR_L))  sel_l = SRC_P;
  end
endmodule

// File: rtl/tor_switch.sv
module tor_switch
  import tor_pkg::*;
#(
  parameter int XW         = 2,
  parameter int YW         = 2,
  parameter int PW         = 32,
  parameter int MY_X       = 1,
  parameter int MY_Y       = 2,
  parameter int TURN_DEPTH = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          w_valid,
  input  logic [XW-1:0] w_dx,
  input  logic [YW-1:0] w_dy,
  input  logic [PW-1:0] w_data,
  input  logic          n_valid,
  input  logic [XW-1:0] n_dx,
  input  logic [YW-1:0] n_dy,
  input  logic [PW-1:0] n_data,
  input  logic          pe_valid,
  input  logic [XW-1:0] pe_dx,
  input  logic [YW-1:0] pe_dy,
  input  logic [PW-1:0] pe_data,
  output logic          pe_grant,
  output logic          e_valid,
  output logic [XW-1:0] e_dx,
  output logic [YW-1:0] e_dy,
  output logic [PW-1:0] e_data,
  output logic          s_valid,
  output logic [XW-1:0] s_dx,
  output logic [YW-1:0] s_dy,
  output logic [PW-1:0] s_data,
  output logic          l_valid,
  output logic [XW-1:0] l_dx,
  output logic [YW-1:0] l_dy,
  output logic [PW-1:0] l_data,
  output logic          ovf
);
  localparam int PKT_W = XW + YW + PW;

  logic [PKT_W-1:0] w_pkt, n_pkt, pe_pkt, q_pkt;
  logic [XW-1:0]    q_dx;
  logic [YW-1:0]    q_dy;
  dir_e             w_dir, n_dir, pe_dir, q_dir;

  // named internal events for the checker
  logic q_empty, q_full, q_pop, fifo_push, fifo_drop;
  src_e sel_e, sel_s, sel_l;
  src_e sel [NUM_OUT];

  assign w_pkt  = {w_dx, w_dy, w_data};
  assign n_pkt  = {n_dx, n_dy, n_data};
  assign pe_pkt = {pe_dx, pe_dy, pe_data};
  assign q_dx   = q_pkt[PKT_W-1 -: XW];
  assign q_dy   = q_pkt[PW +: YW];

  assign w_dir  = row_route(int'(w_dx), int'(w_dy), MY_X, MY_Y);
  assign pe_dir = row_route(int'(pe_dx), int'(pe_dy), MY_X, MY_Y);
  assign q_dir  = row_route(int'(q_dx), int'(q_dy), MY_X, MY_Y);
  assign n_dir  = col_route(int'(n_dy), MY_Y);

  tor_arb u_arb (
    .w_valid  (w_valid),
    .w_dir    (w_dir),
    .n_valid  (n_valid),
    .n_dir    (n_dir),
    .q_avail  (!q_empty),
    .q_dir    (q_dir),
    .pe_valid (pe_valid),
    .pe_dir   (pe_dir),
    .w_turn   (fifo_push),
    .q_pop    (q_pop),
    .pe_grant (pe_grant),
    .sel_e    (sel_e),
    .sel_s    (sel_s),
    .sel_l    (sel_l)
  );

  tor_fifo #(.W(PKT_W), .DEPTH(TURN_DEPTH)) u_turn_q (
    .clk   (clk),
    .rst   (rst),
    .push  (fifo_push),
    .din   (w_pkt),
    .pop   (q_pop),
    .dout  (q_pkt),
    .empty (q_empty),
    .full  (q_full),
    .drop  (fifo_drop)
  );

  always_ff @(posedge clk) begin
    if (rst)            ovf <= 1'b0;
    else if (fifo_drop) ovf <= 1'b1;
  end

  assign sel[0] = sel_e;
  assign sel[1] = sel_s;
  assign sel[2] = sel_l;

  logic             o_v   [NUM_OUT];
  logic [PKT_W-1:0] o_pkt [NUM_OUT];

  for (genvar p = 0; p < NUM_OUT; p++) begin : g_out
    logic [PKT_W-1:0] mux;
    always_comb begin
      case (sel[p])
        SRC_W:   mux = w_pkt;
        SRC_N:   mux = n_pkt;
        SRC_Q:   mux = q_pkt;
        SRC_P:   mux = pe_pkt;
        default: mux = '0;
      endcase
    end
    always_ff @(posedge clk) begin
      if (rst) begin
        o_v[p]   <= 1'b0;
        o_pkt[p] <= '0;
      end else begin
        o_v[p]   <= (sel[p] != SRC_NONE);
        o_pkt[p] <= mux;
      end
    end
  end

  assign e_valid = o_v[0];
  assign s_valid = o_v[1];
  assign l_valid = o_v[2];
  assign {e_dx, e_dy, e_data} = o_pkt[0];
  assign {s_dx, s_dy, s_data} = o_pkt[1];
  assign {l_dx, l_dy, l_data} = o_pkt[2];
endmodule

// File: rtl/tor_switch_chk.sv
module tor_switch_chk #(
  parameter int XW   = 2,
  parameter int YW   = 2,
  parameter int PW   = 32,
  parameter int MY_X = 1,
  parameter int MY_Y = 2
) (
  input logic          clk,
  input logic          rst,
  input logic          w_valid,
  input logic [XW-1:0] w_dx,
  input logic [PW-1:0] w_data,
  input logic          n_valid,
  input logic [YW-1:0] n_dy,
  input logic [PW-1:0] n_data,
  input logic          pe_valid,
  input logic          pe_grant,
  input logic          e_valid,
  input logic [PW-1:0] e_data,
  input logic          s_valid,
  input logic [PW-1:0] s_data,
  input logic          l_valid,
  input logic [PW-1:0] l_data,
  input logic          q_pop,
  input logic          q_empty,
  input logic          fifo_drop,
  input logic          ovf
);
  localparam logic [XW-1:0] MX = XW'(MY_X);
  localparam logic [YW-1:0] MY = YW'(MY_Y);

  assert_west_pass_R2: assert property (@(posedge clk) disable iff (rst)
    (w_valid && w_dx != MX) |=> (e_valid && e_data == $past(w_data)));

  assert_north_south_R3: assert property (@(posedge clk) disable iff (rst)
    (n_valid && n_dy != MY) |=> (s_valid && s_data == $past(n_data)));

  assert_north_local_R3: assert property (@(posedge clk) disable iff (rst)
    (n_valid && n_dy == MY) |=> (l_valid && l_data == $past(n_data)));

  assert_pop_nonempty_R5: assert property (@(posedge clk) disable iff (rst)
    q_pop |-> !q_empty);

  assert_grant_needs_req_R7: assert property (@(posedge clk) disable iff (rst)
    !pe_valid |-> !pe_grant);

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (rst)
    fifo_drop |=> ovf);

  assert_flag_sticky_R8: assert property (@(posedge clk) disable iff (rst)
    ovf |=> ovf);
endmodule

bind tor_switch tor_switch_chk #(
  .XW(XW), .YW(YW), .PW(PW), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .w_valid   (w_valid),
  .w_dx      (w_dx),
  .w_data    (w_data),
  .n_valid   (n_valid),
  .n_dy      (n_dy),
  .n_data    (n_data),
  .pe_valid  (pe_valid),
  .pe_grant  (pe_grant),
  .e_valid   (e_valid),
  .e_data    (e_data),
  .s_valid   (s_valid),
  .s_data    (s_data),
  .l_valid   (l_valid),
  .l_data    (l_data),
  .q_pop     (q_pop),
  .q_empty   (q_empty),
  .fifo_drop (fifo_drop),
  .ovf       (ovf)
);

// File: tb/tor_switch_bench.sv
module tor_switch_bench;
  localparam int MX = 1;
  localparam int MY = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic w_valid = 0, n_valid = 0, pe_valid = 0;
  logic [1:0] w_dx = 0, w_dy = 0, n_dx = 0, n_dy = 0, pe_dx = 0, pe_dy = 0;
  logic [31:0] w_data = 0, n_data = 0, pe_data = 0;
  logic pe_grant, e_valid, s_valid, l_valid, ovf;
  logic [1:0] e_dx, e_dy, s_dx, s_dy, l_dx, l_dy;
  logic [31:0] e_data, s_data, l_data;

  always #10 clk = ~clk;  // 50 MHz

  tor_switch u_tor_switch (
    .clk(clk), .rst(rst),
    .w_valid(w_valid), .w_dx(w_dx), .w_dy(w_dy), .w_data(w_data),
    .n_valid(n_valid), .n_dx(n_dx), .n_dy(n_dy), .n_data(n_data),
    .pe_valid(pe_valid), .pe_dx(pe_dx), .pe_dy(pe_dy), .pe_data(pe_data),
    .pe_grant(pe_grant),
    .e_valid(e_valid), .e_dx(e_dx), .e_dy(e_dy), .e_data(e_data),
    .s_valid(s_valid), .s_dx(s_dx), .s_dy(s_dy), .s_data(s_data),
    .l_valid(l_valid), .l_dx(l_dx), .l_dy(l_dy), .l_data(l_data),
    .ovf(ovf)
  );

  typedef struct packed {
    int          port;   // 0 east, 1 south, 2 local
    logic [1:0]  dx;
    logic [1:0]  dy;
    logic [31:0] data;   // [31:24] source: 1 west, 2 north, 3 PE
    int          min_cyc;
    bit          exact;
    int          req;
  } item_t;

  item_t sb[$];
  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int exit_port(logic [1:0] dx, logic [1:0] dy);
    if (int'(dx) != MX) return 0;
    if (int'(dy) != MY) return 1;
    return 2;
  endfunction

  task automatic expect_item(int port, logic [1:0] dx, logic [1:0] dy,
                             logic [31:0] d, int mc, bit ex, int req);
    item_t it;
    it.port = port; it.dx = dx; it.dy = dy; it.data = d;
    it.min_cyc = mc; it.exact = ex; it.req = req;
    sb.push_back(it);
  endtask

  // monitor: pops and compares output packets
  task automatic match(int port, logic [1:0] dx, logic [1:0] dy, logic [31:0] d);
    int idx = -1;
    item_t it;
    for (int i = 0; i < sb.size(); i++)
      if (idx < 0 && sb[i].port == port && sb[i].data == d) idx = i;
    checks++;
    if (idx < 0) begin
      errors++;
      $display("FAIL R9 port %0d: unexpected packet data=%h (expected none)", port, d);
      return;
    end
    it = sb[idx];
    for (int j = 0; j < idx; j++)
      if (sb[j].port == port && sb[j].data[31:24] == d[31:24]) begin
        errors++;
        $display("FAIL R9 port %0d: order broken, got %h expected %h", port, d, sb[j].data);
        break;
      end
    if (dx != it.dx || dy != it.dy) begin
      errors++;
      $display("FAIL R%0d port %0d: coords %0d,%0d expected %0d,%0d", it.req, port, dx, dy, it.dx, it.dy);
    end
    if (it.exact ? (cyc != it.min_cyc) : (cyc < it.min_cyc)) begin
      errors++;
      $display("FAIL R%0d port %0d data %h: cycle %0d expected %s%0d", it.req, port, d, cyc,
               it.exact ? "" : ">=", it.min_cyc);
    end
    sb.delete(idx);
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      if (e_valid) match(0, e_dx, e_dy, e_data);
      if (s_valid) match(1, s_dx, s_dy, s_data);
      if (l_valid) match(2, l_dx, l_dy, l_data);
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // drivers (called at a falling edge)
  task automatic send_w(logic [1:0] dx, logic [1:0] dy, logic [31:0] d, int req, bit keep);
    w_valid = 1; w_dx = dx; w_dy = dy; w_data = d;
    if (keep) begin
      if (int'(dx) != MX) expect_item(0, dx, dy, d, cyc + 1, 1, req);
      else                expect_item(exit_port(dx, dy), dx, dy, d, cyc + 2, 0, req);
    end
  endtask

  task automatic send_n(logic [1:0] dy, logic [31:0] d, int req);
    n_valid = 1; n_dx = 2'(MX); n_dy = dy; n_data = d;
    expect_item((int'(dy) != MY) ? 1 : 2, 2'(MX), dy, d, cyc + 1, 1, req);
  endtask

  task automatic try_pe(logic [1:0] dx, logic [1:0] dy, logic [31:0] d, bit exp_g, string req);
    pe_valid = 1; pe_dx = dx; pe_dy = dy; pe_data = d;
    #1;
    check(pe_grant === exp_g, req, "pe_grant", int'(pe_grant), int'(exp_g));
    if (pe_grant) expect_item(exit_port(dx, dy), dx, dy, d, cyc + 1, 1, 6);
  endtask

  task automatic tick();
    @(negedge clk);
    w_valid = 0; n_valid = 0; pe_valid = 0;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst = 0;
    tick();
    // R1: reset state
    check(!e_valid && !s_valid && !l_valid, "R1", "valids after reset", int'(e_valid|s_valid|l_valid), 0);
    check(!ovf, "R1", "ovf after reset", int'(ovf), 0);
    check(!pe_grant, "R1", "grant without request", int'(pe_grant), 0);

    // R2 with R7: west pass-through blocks PE east
    send_w(2'd3, 2'd0, 32'h0100_0001, 2, 1);
    try_pe(2'd0, 2'd1, 32'h0300_0001, 0, "R7");
    tick();
    send_w(2'd2, 2'd3, 32'h0100_0002, 2, 1);
    tick();
    try_pe(2'd0, 2'd1, 32'h0300_0002, 1, "R6");   // east free now
    tick();
    idle(2);

    // R3: north to south and to local
    send_n(2'd0, 32'h0200_0001, 3);
    try_pe(2'd1, 2'd2, 32'h0300_0003, 1, "R7");   // local free
    tick();
    send_n(2'd2, 32'h0200_0002, 3);
    try_pe(2'd1, 2'd2, 32'h0300_0004, 0, "R7");   // local held by north
    tick();
    idle(2);

    // R4: west turning to local, then head blocks PE local
    send_w(2'd1, 2'd2, 32'h0100_0003, 4, 1);
    try_pe(2'd1, 2'd2, 32'h0300_0005, 1, "R7");   // queue still empty
    tick();
    try_pe(2'd1, 2'd2, 32'h0300_0006, 0, "R7");   // head wants local
    tick();
    idle(3);

    // R6: PE to south
    try_pe(2'd1, 2'd0, 32'h0300_0007, 1, "R6");
    tick();
    idle(2);

    // R5: north blocks queue head on south
    send_w(2'd1, 2'd0, 32'h0100_0004, 5, 1);
    send_n(2'd1, 32'h0200_0003, 5);
    tick();
    send_n(2'd3, 32'h0200_0004, 5);
    try_pe(2'd1, 2'd3, 32'h0300_0008, 0, "R7");
    tick();
    try_pe(2'd1, 2'd3, 32'h0300_0009, 0, "R7");   // head draining
    tick();
    try_pe(2'd1, 2'd3, 32'h0300_000A, 1, "R7");
    tick();
    idle(3);
    check(!ovf, "R8", "ovf before overflow", int'(ovf), 0);

    // R8/R9: fill the queue behind north traffic, one extra write is lost
    for (int k = 0; k < 33; k++) begin
      send_n(2'd0, 32'h0200_0100 + 32'(k), 5);
      send_w(2'd1, 2'(k % 2 == 0 ? 0 : 3), 32'h0100_0100 + 32'(k), 9, k < 32);
      if (k == 5) try_pe(2'd1, 2'd1, 32'h0300_000B, 0, "R7");
      tick();
    end
    check(ovf, "R8", "ovf after extra write", int'(ovf), 1);
    idle(40);
    check(ovf, "R8", "ovf sticky", int'(ovf), 1);
    check(sb.size() == 0, "R9", "pending items after drain", sb.size(), 0);

    // R1: reset clears flag
    rst = 1;
    idle(2);
    rst = 0;
    tick();
    check(!ovf, "R1", "ovf after second reset", int'(ovf), 0);
    check(!e_valid && !s_valid && !l_valid, "R1", "valids after second reset", int'(e_valid|s_valid|l_valid), 0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule